// File: doc/BRIEF.md
# Multi-Sink Trace ID Filter

This block sits between one trace stream and several trace sinks. Every incoming beat carries a 7-bit trace ID. Each sink owns a 128-bit enable map, and a beat is copied to every sink whose map has the bit for that ID set. A sink whose bit is clear drops the beat. This lets one sink collect high-rate processor trace while another collects low-rate software trace, so the sparse stream is never pushed out of its buffer by the dense one.

Software programs the maps through a small register port. It can write a whole 32-bit word, or it can OR a single ID into a sink's map without touching the other bits, so sources can be enabled one at a time. A per-sink clear pulse wipes that sink's whole map in one cycle. A per-sink bypass level passes every ID to that sink. Writing all ones into a map has the same effect. The number of sinks is a parameter, and each extra sink adds four map words.

Top module: `trace_id_steer`

## Requirements
- R1: After reset every map word reads 0 and no beat reaches any sink until an ID is programmed.
- R2: Map word w of sink k sits at register address 4*k + w. Word w covers IDs 32*w up to 32*w+31, with bit 0 holding the lowest ID. `reg_rdata` returns the addressed word in the same cycle.
- R3: An accepted beat with ID n is presented on sink k's output in the cycle after acceptance, with its ID and data unchanged, exactly when bit n of sink k's map is set or that sink is bypassed. Otherwise sink k does not receive it.
- R4: A write with `reg_set` high ORs bit `reg_wdata[6:0]` into the map of sink `reg_addr[2+:]`. The low two address bits are ignored and all other bits keep their values. A write with `reg_set` low replaces the addressed word.
- R5: A `sink_clr[k]` pulse zeroes all 128 bits of sink k's map. It wins over a register write to the same sink in the same cycle and leaves the other sinks untouched.
- R6: While `sink_bypass[k]` is high, sink k receives every accepted beat. Its stored map is not changed.
- R7: A map of all ones passes every ID, including 0 and 127. No ID value is treated as reserved.
- R8: `in_ready` is high exactly when every sink that would take the current beat can take it. A beat taken by no sink is consumed and dropped.
- R9: While a sink's `out_valid` is high and its `out_ready` is low, that sink's output beat stays unchanged.
- R10: A beat accepted in the same cycle as a map change uses the old map. The beat accepted in the next cycle uses the new map.
- R11: A stalled sink blocks only beats that it would take itself. Beats for other sinks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_set | input | 1 | Write mode: 1 = OR one ID bit, 0 = replace word |
| reg_addr | input | ADDR_W | Write address (sink*4 + word) |
| reg_wdata | input | 32 | Word data, or ID in the low bits for a set-bit write |
| reg_rd_addr | input | ADDR_W | Read address |
| reg_rdata | output | 32 | Addressed map word |
| sink_clr | input | NUM_SINKS | Per-sink map clear pulse |
| sink_bypass | input | NUM_SINKS | Per-sink pass-all level |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_id | input | ID_W | Trace ID of the input beat |
| in_data | input | DATA_W | Payload of the input beat |
| out_valid | output | NUM_SINKS | Per-sink output valid |
| out_ready | input | NUM_SINKS | Per-sink output ready |
| out_id | output | NUM_SINKS*ID_W | Per-sink output ID, sink k in slice k |
| out_data | output | NUM_SINKS*DATA_W | Per-sink output payload, sink k in slice k |

## Verification
The bench targets the edges of the ID space:
- IDs 0 and 127 decide whether a word index or bit position is off by one, because a wrong decode steers those beats to the wrong sink or drops them.
- A set-bit write is aimed at a non-zero word address, so a decoder that used the full address would corrupt a neighbouring sink.
- A map write is issued in the same cycle as a matching beat, which exposes a design that forwards the new map combinationally.
- A clear is issued together with a write, which shows whether the clear takes priority.
- One sink is stalled while beats go to the other sink, to no sink, and back to the stalled sink. A design that pulled ready low globally would block the free sink, and one that ignored the stall would overwrite a held beat.

// File: rtl/trace_filt_pkg.sv
package trace_filt_pkg;

  localparam int WORD_BITS = 32;

  // word index holding a given trace ID
  function automatic int word_of(input int id);
    return id / WORD_BITS;
  endfunction

  // bit position of a trace ID inside its word
  function automatic int bit_of(input int id);
    return id % WORD_BITS;
  endfunction

  // single-bit mask for an ID inside its word
  function automatic logic [WORD_BITS-1:0] id_mask(input int id);
    return WORD_BITS'(1) << bit_of(id);
  endfunction

endpackage

// File: rtl/tf_map_bank.sv
module tf_map_bank
  import trace_filt_pkg::*;
#(
  parameter  int ID_W   = 7,
  localparam int IDS    = 1 << ID_W,
  localparam int WORDS  = IDS / WORD_BITS,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_we,
  input  logic [WIDX_W-1:0]    word_idx,
  input  logic [WORD_BITS-1:0] word_data,
  input  logic                 set_en,
  input  logic [ID_W-1:0]      set_id,
  input  logic                 clr,
  output logic [IDS-1:0]       map
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_BITS-1:0] q;
    logic                 set_here;
    logic                 write_here;

    assign set_here   = set_en && (word_of(32'(set_id)) == w);
    assign write_here = word_we && (word_idx == WIDX_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n)          q <= '0;
      else if (clr)        q <= '0;
      else if (write_here) q <= word_data;
      else if (set_here)   q <= q | id_mask(32'(set_id));
    end

    assign map[w*WORD_BITS +: WORD_BITS] = q;
  end

endmodule

// File: rtl/tf_id_lookup.sv
module tf_id_lookup #(
  parameter  int ID_W = 7,
  localparam int IDS  = 1 << ID_W
) (
  input  logic [IDS-1:0]  map,
  input  logic [ID_W-1:0] id,
  input  logic            bypass,
  output logic            hit
);

  assign hit = bypass | map[id];

endmodule

// File: rtl/tf_out_stage.sv
module tf_out_stage #(
  parameter int ID_W   = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ID_W-1:0]   ld_id,
  input  logic [DATA_W-1:0] ld_data,
  output logic              space,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [ID_W-1:0]   o_id,
  output logic [DATA_W-1:0] o_data
);

  assign space = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_id    <= '0;
      o_data  <= '0;
    end else if (load) begin
      o_valid <= 1'b1;
      o_id    <= ld_id;
      o_data  <= ld_data;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/trace_id_steer.sv
module trace_id_steer
  import trace_filt_pkg::*;
#(
  parameter  int NUM_SINKS = 2,
  parameter  int ID_W      = 7,
  parameter  int DATA_W    = 32,
  localparam int IDS       = 1 << ID_W,
  localparam int WORDS     = IDS / WORD_BITS,
  localparam int WIDX_W    = $clog2(WORDS),
  localparam int ADDR_W    = $clog2(NUM_SINKS * WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_set,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [WORD_BITS-1:0]        reg_wdata,
  input  logic [ADDR_W-1:0]           reg_rd_addr,
  output logic [WORD_BITS-1:0]        reg_rdata,
  input  logic [NUM_SINKS-1:0]        sink_clr,
  input  logic [NUM_SINKS-1:0]        sink_bypass,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ID_W-1:0]             in_id,
  input  logic [DATA_W-1:0]           in_data,
  output logic [NUM_SINKS-1:0]        out_valid,
  input  logic [NUM_SINKS-1:0]        out_ready,
  output logic [NUM_SINKS*ID_W-1:0]   out_id,
  output logic [NUM_SINKS*DATA_W-1:0] out_data
);

  localparam int SIDX_W = ADDR_W - WIDX_W;

  logic [SIDX_W-1:0]        wr_sink;
  logic [WIDX_W-1:0]        wr_word;
  logic [NUM_SINKS*IDS-1:0] map_flat;
  logic [NUM_SINKS-1:0]     hit_vec;
  logic [NUM_SINKS-1:0]     space_vec;
  logic [NUM_SINKS-1:0]     load_vec;
  logic                     accept;

  assign wr_sink = reg_addr[ADDR_W-1:WIDX_W];
  assign wr_word = reg_addr[WIDX_W-1:0];

  for (genvar k = 0; k < NUM_SINKS; k++) begin : g_sink
    logic sel;
    assign sel         = reg_wr && (wr_sink == SIDX_W'(k));
    assign load_vec[k] = accept & hit_vec[k];

    tf_map_bank #(.ID_W(ID_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_we   (sel & ~reg_set),
      .word_idx  (wr_word),
      .word_data (reg_wdata),
      .set_en    (sel & reg_set),
      .set_id    (reg_wdata[ID_W-1:0]),
      .clr       (sink_clr[k]),
      .map       (map_flat[k*IDS +: IDS])
    );

    tf_id_lookup #(.ID_W(ID_W)) u_look (
      .map    (map_flat[k*IDS +: IDS]),
      .id     (in_id),
      .bypass (sink_bypass[k]),
      .hit    (hit_vec[k])
    );

    tf_out_stage #(.ID_W(ID_W), .DATA_W(DATA_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_vec[k]),
      .ld_id   (in_id),
      .ld_data (in_data),
      .space   (space_vec[k]),
      .o_valid (out_valid[k]),
      .o_ready (out_ready[k]),
      .o_id    (out_id[k*ID_W +: ID_W]),
      .o_data  (out_data[k*DATA_W +: DATA_W])
    );
  end

  // a beat waits only for sinks that actually take it
  assign in_ready = &(~hit_vec | space_vec);
  assign accept   = in_valid & in_ready;

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < NUM_SINKS; s++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (reg_rd_addr == ADDR_W'(s*WORDS + w))
          reg_rdata = map_flat[s*IDS + w*WORD_BITS +: WORD_BITS];
      end
    end
  end

endmodule

// File: rtl/trace_id_steer_chk.sv
module trace_id_steer_chk #(
  parameter  int NUM_SINKS = 2,
  parameter  int ID_W      = 7,
  parameter  int DATA_W    = 32,
  localparam int IDS       = 1 << ID_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [ID_W-1:0]             in_id,
  input logic [DATA_W-1:0]           in_data,
  input logic [NUM_SINKS-1:0]        out_valid,
  input logic [NUM_SINKS-1:0]        out_ready,
  input logic [NUM_SINKS*ID_W-1:0]   out_id,
  input logic [NUM_SINKS*DATA_W-1:0] out_data,
  input logic [NUM_SINKS-1:0]        sink_clr,
  input logic [NUM_SINKS-1:0]        hit_vec,
  input logic [NUM_SINKS*IDS-1:0]    map_flat
);

  for (genvar k = 0; k < NUM_SINKS; k++) begin : g_chk
    assert_deliver_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && hit_vec[k] |=>
        out_valid[k] && out_id[k*ID_W +: ID_W] == $past(in_id) &&
        out_data[k*DATA_W +: DATA_W] == $past(in_data));

    assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !hit_vec[k] && (!out_valid[k] || out_ready[k]) |=>
        !out_valid[k]);

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sink_clr[k] |=> map_flat[k*IDS +: IDS] == '0);

    assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && hit_vec[k] |-> !out_valid[k] || out_ready[k]);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[k] && !out_ready[k] |=>
        out_valid[k] && $stable(out_id[k*ID_W +: ID_W]) &&
        $stable(out_data[k*DATA_W +: DATA_W]));
  end

endmodule

bind trace_id_steer trace_id_steer_chk #(
  .NUM_SINKS (NUM_SINKS),
  .ID_W      (ID_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_id     (in_id),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_id    (out_id),
  .out_data  (out_data),
  .sink_clr  (sink_clr),
  .hit_vec   (hit_vec),
  .map_flat  (map_flat)
);

// File: tb/trace_id_steer_tb.sv
module trace_id_steer_tb;

  localparam int NS  = 2;
  localparam int IDW = 7;
  localparam int DW  = 32;
  localparam int IDS = 128;
  localparam int WDS = 4;
  localparam int AW  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_set = 1'b0;
  logic [AW-1:0]     reg_addr = '0, reg_rd_addr = '0;
  logic [31:0]       reg_wdata = '0, reg_rdata;
  logic [NS-1:0]     sink_clr = '0, sink_bypass = '0;
  logic              in_valid = 1'b0, in_ready;
  logic [IDW-1:0]    in_id = '0;
  logic [DW-1:0]     in_data = '0;
  logic [NS-1:0]     out_valid, out_ready = '1;
  logic [NS*IDW-1:0] out_id;
  logic [NS*DW-1:0]  out_data;

  int vec = 0;
  int bad = 0;

  logic [IDS-1:0] m_map  [NS];
  logic           m_ov   [NS];
  logic [IDW-1:0] m_id   [NS];
  logic [DW-1:0]  m_data [NS];

  // 50 MHz: 20 time-unit period
  always #10 clk = ~clk;

  trace_id_steer #(.NUM_SINKS(NS), .ID_W(IDW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_set(reg_set),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr),
    .reg_rdata(reg_rdata), .sink_clr(sink_clr), .sink_bypass(sink_bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_data(out_data)
  );

  function automatic logic [DW-1:0] stamp(input logic [IDW-1:0] id);
    return 32'hA500_0000 | {25'd0, id};
  endfunction

  function automatic logic passes(input int k, input logic [IDW-1:0] id);
    return sink_bypass[k] | m_map[k][id];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; reg_wr = 1'b0; reg_set = 1'b0; sink_clr = '0;
  endtask

  // one clock: check in_ready, advance, update model, check outputs
  task automatic step(input string req);
    logic [NS-1:0] hit;
    logic          rdy_e, fire;
    int            s, w;
    #5;
    rdy_e = 1'b1;
    for (int k = 0; k < NS; k++) begin
      hit[k] = passes(k, in_id);
      if (hit[k] && m_ov[k] && !out_ready[k]) rdy_e = 1'b0;
    end
    chk(in_ready === rdy_e, "R8", in_ready, rdy_e);
    fire = in_valid & rdy_e;
    @(posedge clk);
    for (int k = 0; k < NS; k++) begin
      if (fire && hit[k]) begin
        m_ov[k] = 1'b1; m_id[k] = in_id; m_data[k] = in_data;
      end else if (out_ready[k]) m_ov[k] = 1'b0;
    end
    s = int'(reg_addr) / WDS;
    w = int'(reg_addr) % WDS;
    for (int k = 0; k < NS; k++) begin
      if (sink_clr[k]) m_map[k] = '0;
      else if (reg_wr && s == k) begin
        if (reg_set) m_map[k][reg_wdata[IDW-1:0]] = 1'b1;
        else m_map[k][w*32 +: 32] = reg_wdata;
      end
    end
    #1;
    for (int k = 0; k < NS; k++) begin
      chk(out_valid[k] === m_ov[k] &&
          (!m_ov[k] || (out_id[k*IDW +: IDW] === m_id[k] &&
                        out_data[k*DW +: DW] === m_data[k])), req,
          {out_valid[k], out_id[k*IDW +: IDW], out_data[k*DW +: DW]},
          {m_ov[k], m_id[k], m_data[k]});
    end
    @(negedge clk);
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string req);
    reg_rd_addr = AW'(addr);
    #1;
    chk(reg_rdata === exp, req, reg_rdata, exp);
    step(req);
  endtask

  task automatic beat(input int id, input string req);
    idle(); in_valid = 1'b1; in_id = IDW'(id); in_data = stamp(IDW'(id));
    step(req);
    idle();
  endtask

  task automatic wr_word(input int addr, input logic [31:0] d, input string req);
    idle(); reg_wr = 1'b1; reg_set = 1'b0; reg_addr = AW'(addr); reg_wdata = d;
    step(req);
    idle();
  endtask

  task automatic set_id(input int addr, input int id, input string req);
    idle(); reg_wr = 1'b1; reg_set = 1'b1; reg_addr = AW'(addr); reg_wdata = 32'(id);
    step(req);
    idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240619));
    for (int k = 0; k < NS; k++) begin
      m_map[k] = '0; m_ov[k] = 1'b0; m_id[k] = '0; m_data[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: maps clear and nothing passes after reset
    for (int a = 0; a < NS*WDS; a++) rd(a, 32'h0, "R1");
    beat(5, "R1");

    // R4 / R2: enable IDs 1,2,3 one by one on sink 0
    set_id(0, 1, "R4"); set_id(0, 2, "R4"); set_id(0, 3, "R4");
    rd(0, 32'h0000_000E, "R4");
    // set-bit with a non-zero word address: low address bits ignored
    set_id(5, 40, "R4");
    rd(5, 32'h0000_0100, "R2");
    rd(1, 32'h0, "R2");
    wr_word(3, 32'h8000_0000, "R2");
    rd(3, 32'h8000_0000, "R2");

    // R3: steering by ID, including top ID and an unmapped ID 0
    beat(2, "R3"); beat(40, "R3"); beat(127, "R3"); beat(0, "R3"); beat(3, "R3");

    // R10: map write in the same cycle as a matching beat
    idle(); reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h0000_0080;
    in_valid = 1'b1; in_id = 7'd7; in_data = stamp(7'd7);
    step("R10");
    idle();
    beat(7, "R10");

    // R5: clear wins over a same-cycle write, other sink kept
    idle(); sink_clr = 2'b01; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'hFFFF_FFFF;
    step("R5");
    idle();
    for (int w = 0; w < WDS; w++) rd(w, 32'h0, "R5");
    rd(4, 32'h0000_0080, "R5");
    beat(3, "R5");

    // R7: all-ones map on sink 1 passes the extreme IDs
    for (int w = 0; w < WDS; w++) wr_word(4 + w, 32'hFFFF_FFFF, "R7");
    beat(0, "R7"); beat(127, "R7"); beat(64, "R7");

    // R6: bypass sink 0 with an empty map, map untouched
    sink_bypass = 2'b01;
    beat(99, "R6"); beat(0, "R6");
    sink_bypass = 2'b00;
    rd(3, 32'h0, "R6");
    beat(99, "R6");

    // R8 / R9 / R11: stall sink 1
    idle(); sink_clr = 2'b11; step("R5"); idle();
    set_id(4, 10, "R11"); set_id(0, 20, "R11");
    out_ready = 2'b01;
    beat(10, "R9");
    idle(); in_valid = 1'b1; in_id = 7'd10; in_data = 32'h1234_5678;
    step("R8"); step("R9");
    idle();
    beat(20, "R11");
    beat(30, "R8");
    out_ready = 2'b11;
    idle(); step("R9"); step("R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      idle();
      in_valid  = ($urandom % 10) < 7;
      in_id     = ($urandom % 2) ? IDW'($urandom % 8) : IDW'($urandom);
      in_data   = $urandom;
      out_ready = NS'($urandom) | NS'(($urandom % 4) == 0 ? 0 : $urandom);
      if (($urandom % 10) == 0) begin
        reg_wr    = 1'b1;
        reg_set   = $urandom % 2;
        reg_addr  = AW'($urandom);
        reg_wdata = ($urandom % 2) ? 32'($urandom % 8) : $urandom;
      end
      if (($urandom % 50) == 0) sink_clr = NS'($urandom);
      if (($urandom % 64) == 0) sink_bypass = NS'($urandom);
      step("R3");
    end
    idle(); out_ready = '1; step("R9");

    finish_run();
  end

endmodule